// File: doc/BRIEF.md
# Down-Counting Interval Timer with Compare Match

This block is a memory-mapped interval timer built around a down-counter. Software programs a start value, a compare value and a mode word through a small register bus. While the timer runs, every cycle in which the clock-enable input is high moves the counter down by one. When the counter reaches zero it either reloads from the programmed start value, which gives a periodic timer, or wraps to the all-ones value, which gives a free-running timer.

A compare unit watches the counter. When the counter passes the compare value while running, a sticky flag is raised, and the flag drives a level interrupt while compare interrupts are enabled. The match fires on every round for every compare value, zero included. A software-reset bit in the mode word returns the data registers to their reset values and keeps the run and mode bits. A load-force bit makes a write of the start value take effect on the counter at once.

The bus is a single-cycle valid/write interface with a byte address. Registers sit on 32-bit word boundaries, and reads return data in the same cycle.

Top module: `tick_down_timer`

## Requirements
- R1: The register index is the byte address divided by four: 0 mode word, 1 flag, 2 start value, 3 compare value, 4 counter. Any other index reads zero. Read data is zero unless `bus_valid` is high and `bus_write` is low.
- R2: Only mode-word bits 25..0 are stored, and bits 31..26 read as zero. Bit 16 (software reset) acts on the write and always reads as zero. Mode-word bit positions: 0 run, 1 start mode, 2 compare interrupt enable, 3 reload, 16 software reset, 17 load force, 18 to 21 hold bits for debug, wait, doze and stop.
- R3: After `rst_n` is low at a clock edge, the mode word, flag and compare value are 0, and the start value and counter are all ones. `irq` is low.
- R4: A mode-word write with bit 16 set stores the written value ANDed with bits 0, 1 and 18 to 21, and clears every other mode bit. The same write clears the flag and compare value, sets the start value and counter to all ones, and the counter keeps running if the run bit survives.
- R5: While the run bit is set, each cycle with `tick_en` high decrements the counter by one. While the run bit is clear, the counter holds.
- R6: When a tick arrives with the counter at zero, the counter loads the start value if the reload bit is set, and all ones otherwise.
- R7: A mode write that changes the run bit from 0 to 1 with start mode set loads the counter from the start value if the written reload bit is set, and from all ones otherwise. Without start mode, or with run already set, the counter keeps its value.
- R8: A start-value write while load force is set copies the value into the counter in the same edge, and this wins over a tick in that cycle. Without load force, the counter is unaffected.
- R9: With run and compare interrupt enable both set, a tick while the counter equals the compare value sets the flag. This happens on every round, including for a compare value of 0. A compare value above the reloaded start value never matches.
- R10: With compare interrupt enable clear or run clear, no match sets the flag. Setting compare interrupt enable while running leaves the counter untouched.
- R11: Writing 1 to flag bit 0 clears it, and writing 0 leaves it set. A match in the same cycle as a clear leaves the flag set.
- R12: `irq` is high exactly when the flag is set and compare interrupt enable is set.
- R13: The counter register is read-only, and writes to index 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Level compare interrupt |

## Verification
The compare function is swept over every compare value from 0 up to the start value in periodic mode. Each value is checked for no flag one tick early, for the flag on the exact tick, and again one full period later. This separates an off-by-one in match timing, a missing match at zero and a match that fires only once. Reload and wrap are each driven through zero, so a swapped mode bit shows up. Ticks are collided with start-value writes and flag clears to expose the wrong priority. Separate runs enable the timer with and without start mode and with the run bit already set, which tells initialisation apart from resumption.

// File: rtl/tdt_pkg.sv
// Shared constants and types for the down-counting interval timer.
// Assumes a 32-bit data bus and word-aligned register indexes.
package tdt_pkg;

    localparam int BUS_W     = 32;
    localparam int CTRL_BITS = 26;

    // Mode-word bit positions (software visible)
    localparam int B_RUN        = 0;
    localparam int B_START_MODE = 1;
    localparam int B_CMP_IE     = 2;
    localparam int B_RELOAD     = 3;
    localparam int B_SOFT_RST   = 16;
    localparam int B_LOAD_FORCE = 17;
    localparam int B_HOLD_DBG   = 18;
    localparam int B_HOLD_WAIT  = 19;
    localparam int B_HOLD_DOZE  = 20;
    localparam int B_HOLD_STOP  = 21;

    // Mode bits that survive a software reset
    localparam logic [BUS_W-1:0] KEEP_MASK =
        (BUS_W'(1) << B_RUN)       | (BUS_W'(1) << B_START_MODE) |
        (BUS_W'(1) << B_HOLD_DBG)  | (BUS_W'(1) << B_HOLD_WAIT)  |
        (BUS_W'(1) << B_HOLD_DOZE) | (BUS_W'(1) << B_HOLD_STOP);

    typedef enum logic [2:0] {
        IDX_MODE  = 3'd0,
        IDX_FLAG  = 3'd1,
        IDX_START = 3'd2,
        IDX_CMP   = 3'd3,
        IDX_COUNT = 3'd4
    } reg_idx_e;

    // Decoded view of the mode bits the datapath uses
    typedef struct packed {
        logic run;
        logic start_mode;
        logic cmp_ie;
        logic reload;
        logic load_force;
    } mode_view_t;

endpackage

// File: rtl/tdt_regfile.sv
// Register file and bus decoder for the interval timer.
// Holds the mode word, start value and compare value. It turns bus writes
// into one-cycle strobes for the counter and the compare unit.
// Assumes at most one bus access per cycle and ADDR_W >= 5.
module tdt_regfile
    import tdt_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic [WIDTH-1:0]   count_i,
    input  logic               flag_i,
    output logic [BUS_W-1:0]   rdata_o,
    output mode_view_t         mode_o,
    output logic [WIDTH-1:0]   start_val_o,
    output logic [WIDTH-1:0]   cmp_val_o,
    output logic [WIDTH-1:0]   force_val_o,
    output logic               soft_rst_o,
    output logic               init_o,
    output logic               init_from_start_o,
    output logic               force_o,
    output logic               flag_clr_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [IDX_W-1:0]     word_idx;
    logic                 wr_mode, wr_flag, wr_start, wr_cmp, rd_en;
    logic [CTRL_BITS-1:0] mode_q, mode_next;
    logic [WIDTH-1:0]     start_q, cmp_q;
    logic [BUS_W-1:0]     mode_rd;
    logic                 unused_addr_lsb;

    assign word_idx        = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];

    // Decode one write strobe per register
    always_comb begin
        wr_mode  = bus_valid && bus_write && (word_idx == IDX_W'(IDX_MODE));
        wr_flag  = bus_valid && bus_write && (word_idx == IDX_W'(IDX_FLAG));
        wr_start = bus_valid && bus_write && (word_idx == IDX_W'(IDX_START));
        wr_cmp   = bus_valid && bus_write && (word_idx == IDX_W'(IDX_CMP));
        rd_en    = bus_valid && !bus_write;
    end

    // Form the stored mode word: reset bit never kept, reset masks the rest
    always_comb begin
        mode_next             = bus_wdata[CTRL_BITS-1:0];
        mode_next[B_SOFT_RST] = 1'b0;
        if (bus_wdata[B_SOFT_RST]) begin
            mode_next = mode_next & KEEP_MASK[CTRL_BITS-1:0];
        end
    end

    // Mode word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= mode_next;
        end
    end

    // Start value register: software reset forces all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= ALL_ONES;
        end else if (wr_mode && bus_wdata[B_SOFT_RST]) begin
            start_q <= ALL_ONES;
        end else if (wr_start) begin
            start_q <= bus_wdata[WIDTH-1:0];
        end
    end

    // Compare value register: software reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_mode && bus_wdata[B_SOFT_RST]) begin
            cmp_q <= '0;
        end else if (wr_cmp) begin
            cmp_q <= bus_wdata[WIDTH-1:0];
        end
    end

    // Strobes that steer the counter and compare unit
    always_comb begin
        soft_rst_o        = wr_mode && bus_wdata[B_SOFT_RST];
        init_o            = wr_mode && !bus_wdata[B_SOFT_RST]
                            && bus_wdata[B_RUN] && !mode_q[B_RUN]
                            && bus_wdata[B_START_MODE];
        init_from_start_o = bus_wdata[B_RELOAD];
        force_o           = wr_start && mode_q[B_LOAD_FORCE];
        force_val_o       = bus_wdata[WIDTH-1:0];
        flag_clr_o        = wr_flag && bus_wdata[0];
    end

    // Decoded mode bits for the datapath
    always_comb begin
        mode_o.run        = mode_q[B_RUN];
        mode_o.start_mode = mode_q[B_START_MODE];
        mode_o.cmp_ie     = mode_q[B_CMP_IE];
        mode_o.reload     = mode_q[B_RELOAD];
        mode_o.load_force = mode_q[B_LOAD_FORCE];
    end

    // Zero-extend the stored mode bits to bus width
    generate
        if (CTRL_BITS < BUS_W) begin : g_mode_pad
            assign mode_rd = {{(BUS_W-CTRL_BITS){1'b0}}, mode_q};
        end else begin : g_mode_full
            assign mode_rd = mode_q;
        end
    endgenerate

    // Same-cycle read multiplexer
    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            case (word_idx)
                IDX_W'(IDX_MODE):  rdata_o = mode_rd;
                IDX_W'(IDX_FLAG):  rdata_o[0] = flag_i;
                IDX_W'(IDX_START): rdata_o[WIDTH-1:0] = start_q;
                IDX_W'(IDX_CMP):   rdata_o[WIDTH-1:0] = cmp_q;
                IDX_W'(IDX_COUNT): rdata_o[WIDTH-1:0] = count_i;
                default:           rdata_o = '0;
            endcase
        end
    end

    assign start_val_o = start_q;
    assign cmp_val_o    = cmp_q;

endmodule

// File: rtl/tdt_downcount.sv
// Down-counter of the interval timer.
// Priority, highest first: software reset, forced load, run-start
// initialisation, tick decrement. At zero a tick reloads or wraps.
// Assumes the strobes are mutually exclusive because they come from one bus write.
module tdt_downcount #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic             reload,
    input  logic [WIDTH-1:0] start_val,
    input  logic             soft_rst,
    input  logic             force_ld,
    input  logic [WIDTH-1:0] force_val,
    input  logic             init,
    input  logic             init_from_start,
    output logic [WIDTH-1:0] count_o,
    output logic             step_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] roll_val;

    // A counting step happens only while running and ticked
    assign step_o = run && tick_en;

    // Value taken after passing zero
    assign roll_val = reload ? start_val : ALL_ONES;

    // Counter register with its load priorities
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ALL_ONES;
        end else if (soft_rst) begin
            cnt_q <= ALL_ONES;
        end else if (force_ld) begin
            cnt_q <= force_val;
        end else if (init) begin
            cnt_q <= init_from_start ? start_val : ALL_ONES;
        end else if (step_o) begin
            cnt_q <= (cnt_q == '0) ? roll_val : cnt_q - 1'b1;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/tdt_match.sv
// Compare unit of the interval timer.
// A step taken while the counter equals the compare value sets a sticky flag.
// The flag is gated to the interrupt by the compare enable. A match wins
// over a clear, and a software reset wins over both.
// Assumes the step and mode inputs are registered state from the same clock.
module tdt_match #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             cmp_ie,
    input  logic [WIDTH-1:0] count,
    input  logic [WIDTH-1:0] cmp_val,
    input  logic             soft_rst,
    input  logic             flag_clr,
    output logic             flag_o,
    output logic             irq_o
);

    logic hit;
    logic flag_q;

    // Match detection on the step leaving the compare value
    assign hit = step && cmp_ie && (count == cmp_val);

    // Sticky flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (soft_rst) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q && cmp_ie;

endmodule

// File: rtl/tick_down_timer.sv
// Top of the down-counting interval timer with compare match.
// Connects the register file, the down-counter and the compare unit.
// Assumes a synchronous active-low reset and WIDTH <= 32.
module tick_down_timer
    import tdt_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    mode_view_t       mode_w;
    logic [WIDTH-1:0] cnt_w, start_w, cmp_w, force_val_w;
    logic             flag_w, step_w;
    logic             soft_rst_w, init_w, init_from_start_w, force_w, flag_clr_w;

    tdt_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk               (clk),
        .rst_n             (rst_n),
        .bus_valid         (bus_valid),
        .bus_write         (bus_write),
        .bus_addr          (bus_addr),
        .bus_wdata         (bus_wdata),
        .count_i           (cnt_w),
        .flag_i            (flag_w),
        .rdata_o           (bus_rdata),
        .mode_o            (mode_w),
        .start_val_o       (start_w),
        .cmp_val_o         (cmp_w),
        .force_val_o       (force_val_w),
        .soft_rst_o        (soft_rst_w),
        .init_o            (init_w),
        .init_from_start_o (init_from_start_w),
        .force_o           (force_w),
        .flag_clr_o        (flag_clr_w)
    );

    tdt_downcount #(.WIDTH(WIDTH)) u_count (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick_en         (tick_en),
        .run             (mode_w.run),
        .reload          (mode_w.reload),
        .start_val       (start_w),
        .soft_rst        (soft_rst_w),
        .force_ld        (force_w),
        .force_val       (force_val_w),
        .init            (init_w),
        .init_from_start (init_from_start_w),
        .count_o         (cnt_w),
        .step_o          (step_w)
    );

    tdt_match #(.WIDTH(WIDTH)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step_w),
        .cmp_ie   (mode_w.cmp_ie),
        .count    (cnt_w),
        .cmp_val  (cmp_w),
        .soft_rst (soft_rst_w),
        .flag_clr (flag_clr_w),
        .flag_o   (flag_w),
        .irq_o    (irq)
    );

endmodule

// File: rtl/tdt_checker.sv
// Property checker for the interval timer, bound onto the top module.
// It observes the bus, the counter, the flag and the decoded mode bits.
module tdt_checker #(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [WIDTH-1:0]  count,
    input logic [WIDTH-1:0]  start_val,
    input logic [WIDTH-1:0]  cmp_val,
    input logic              flag,
    input logic              run,
    input logic              cmp_ie,
    input logic              reload
);

    logic [ADDR_W-3:0] idx;
    logic wr_mode, wr_flag, wr_start, rd_mode, rd_flag;

    // Local decode of the bus, independent of the register file
    always_comb begin
        idx      = bus_addr[ADDR_W-1:2];
        wr_mode  = bus_valid && bus_write && (idx == '0);
        wr_flag  = bus_valid && bus_write && (idx == (ADDR_W-2)'(1));
        wr_start = bus_valid && bus_write && (idx == (ADDR_W-2)'(2));
        rd_mode  = bus_valid && !bus_write && (idx == '0);
        rd_flag  = bus_valid && !bus_write && (idx == (ADDR_W-2)'(1));
    end

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && count != '0 && !wr_mode && !wr_start)
        |=> count == $past(count) - 1'b1);

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_mode && !wr_start) |=> $stable(count));

    // R6
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && count == '0 && reload && !wr_mode && !wr_start)
        |=> count == $past(start_val));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && count == '0 && !reload && !wr_mode && !wr_start)
        |=> &count);

    // R9
    match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmp_ie && tick_en && count == cmp_val && !wr_mode)
        |=> flag);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_mode && !wr_flag) |=> flag);

    // R12
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && irq) |-> bus_rdata[0]);

    // R2
    mode_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> bus_rdata[31:26] == 6'd0);

endmodule

bind tick_down_timer tdt_checker #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_tdt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (cnt_w),
    .start_val (start_w),
    .cmp_val   (cmp_w),
    .flag      (flag_w),
    .run       (mode_w.run),
    .cmp_ie    (mode_w.cmp_ie),
    .reload    (mode_w.reload)
);

// File: tb/test_tick_down_timer.sv
`timescale 1ns/1ps
// Self-checking bench: 8-bit counter, sweeps every compare value in a period.
module test_tick_down_timer;

    localparam int W = 8;
    localparam logic [31:0] MAXV = 32'hFF;
    localparam logic [31:0] C_RUN = 32'h1, C_SM = 32'h2, C_IE = 32'h4, C_RLD = 32'h8;
    localparam logic [31:0] C_SWR = 32'h1 << 16, C_FRC = 32'h1 << 17;
    localparam logic [31:0] C_HOLD = 32'hF << 18;
    localparam int PER = 20;

    logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    tick_down_timer #(.WIDTH(W), .ADDR_W(5)) i_tick_down_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 5'(idx * 4); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rdchk(int idx, logic [31:0] exp, string tag);
        bus_valid = 1; bus_write = 0; bus_addr = 5'(idx * 4);
        #1;
        chk(tag, bus_rdata, exp);
        bus_valid = 0;
    endtask

    task automatic step(int n);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R3 reset state
        chk("R1 idle read zero", bus_rdata, 0);
        rdchk(0, 0, "R3 mode"); rdchk(1, 0, "R3 flag"); rdchk(2, MAXV, "R3 start");
        rdchk(3, 0, "R3 cmp"); rdchk(4, MAXV, "R3 count"); chk("R3 irq", {31'd0, irq}, 0);
        // R2 writable width
        wr(0, 32'hFC00_0F00); rdchk(0, 32'h0000_0F00, "R2 high bits");
        wr(0, 0);
        // R13 read-only counter, R8 plain start write
        wr(4, 32'h12); rdchk(4, MAXV, "R13 counter write ignored");
        wr(2, 32'h40); rdchk(4, MAXV, "R8 no force"); rdchk(2, 32'h40, "R1 start read");
        rdchk(6, 0, "R1 unmapped");
        // R8 forced load
        wr(0, C_FRC); wr(2, 32'h30); rdchk(4, 32'h30, "R8 force");
        step(5); rdchk(4, 32'h30, "R5 hold when stopped");
        // R7 start init, R5 count, R8 race
        wr(0, C_RUN | C_SM | C_RLD | C_FRC); rdchk(4, 32'h30, "R7 init from start");
        step(3); rdchk(4, 32'h2D, "R5 decrement");
        @(negedge clk); tick_en = 1; bus_valid = 1; bus_write = 1; bus_addr = 5'd8; bus_wdata = 32'h10;
        @(negedge clk); tick_en = 0; bus_valid = 0; bus_write = 0;
        rdchk(4, 32'h10, "R8 force beats tick");
        step(1); rdchk(4, 32'h0F, "R5 decrement");
        wr(0, C_RUN | C_SM | C_RLD | C_FRC); rdchk(4, 32'h0F, "R7 no reinit while running");
        // R6 reload and wrap
        step(15); rdchk(4, 0, "R6 reach zero");
        step(1); rdchk(4, 32'h10, "R6 reload");
        wr(0, C_RUN | C_SM | C_FRC); step(16); step(1); rdchk(4, MAXV, "R6 wrap");
        wr(0, 0); wr(0, C_FRC); wr(2, 5); rdchk(4, 5, "R8 force");
        wr(0, C_RUN | C_SM); rdchk(4, MAXV, "R7 init from max");
        wr(0, 0); wr(0, C_RUN | C_SM | C_RLD); rdchk(4, 5, "R7 init from start");
        step(2); wr(0, 0); wr(0, C_RUN); rdchk(4, 3, "R7 resume without start mode");
        wr(0, 0);
        // R9 sweep of every compare value in the period
        for (int c = 0; c <= PER; c++) begin
            wr(0, 0); wr(1, 1); wr(3, c); wr(2, PER);
            wr(0, C_RUN | C_SM | C_IE | C_RLD);
            step(PER - c);
            rdchk(1, 0, "R9 no early match"); rdchk(4, c, "R9 count at compare");
            chk("R12 irq low", {31'd0, irq}, 0);
            step(1);
            rdchk(1, 1, "R9 match"); chk("R12 irq high", {31'd0, irq}, 1);
            rdchk(4, (c == 0) ? PER : c - 1, "R6 after match");
            wr(1, 1); rdchk(1, 0, "R11 clear");
            step(PER); rdchk(1, 0, "R9 second round early");
            step(1); rdchk(1, 1, "R9 second round match");
        end
        wr(0, 0); wr(1, 1); wr(3, 30); wr(0, C_RUN | C_SM | C_IE | C_RLD);
        step(2 * PER + 2); rdchk(1, 0, "R9 compare above start");
        // R10 compare disabled, enabling mid-run
        wr(0, 0); wr(1, 1); wr(3, 3); wr(0, C_RUN | C_SM | C_RLD);
        step(PER + 1); rdchk(4, PER, "R6 period"); rdchk(1, 0, "R10 no match when disabled");
        chk("R10 irq", {31'd0, irq}, 0);
        step(10); wr(0, C_RUN | C_SM | C_RLD | C_IE); rdchk(4, 10, "R10 enable keeps count");
        step(7); rdchk(1, 0, "R10 before match");
        step(1); rdchk(1, 1, "R10 match after enable");
        wr(1, 1); wr(3, 2); wr(0, C_IE); step(3);
        rdchk(4, 2, "R5 stopped"); rdchk(1, 0, "R10 no match when stopped");
        // R11 match beats clear
        wr(0, C_RUN | C_IE | C_RLD); rdchk(4, 2, "R7 no start mode");
        @(negedge clk); tick_en = 1; bus_valid = 1; bus_write = 1; bus_addr = 5'd4; bus_wdata = 1;
        @(negedge clk); tick_en = 0; bus_valid = 0; bus_write = 0;
        rdchk(1, 1, "R11 match beats clear");
        wr(1, 0); rdchk(1, 1, "R11 write zero keeps");
        wr(1, 1); rdchk(1, 0, "R11 write one clears");
        // R12 interrupt gating
        step(21); rdchk(1, 1, "R9 later round"); chk("R12 irq set", {31'd0, irq}, 1);
        wr(0, C_RUN | C_RLD); chk("R12 irq gated", {31'd0, irq}, 0); rdchk(1, 1, "R12 flag kept");
        wr(0, C_RUN | C_RLD | C_IE); chk("R12 irq back", {31'd0, irq}, 1);
        // R4 software reset
        wr(3, 5); wr(2, 9);
        wr(0, C_RUN | C_SM | C_IE | C_RLD | C_HOLD | 32'h100);
        wr(0, C_RUN | C_SM | C_IE | C_RLD | C_HOLD | 32'h100 | C_SWR);
        rdchk(0, C_RUN | C_SM | C_HOLD, "R4 kept bits");
        rdchk(1, 0, "R4 flag"); rdchk(2, MAXV, "R4 start"); rdchk(3, 0, "R4 cmp");
        rdchk(4, MAXV, "R4 count"); chk("R4 irq", {31'd0, irq}, 0);
        step(1); rdchk(4, MAXV - 1, "R4 still running");
        done = 1;
        summary();
        $finish;
    end

endmodule